// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block watches four condition inputs of a half-bridge gate driver: regulator undervoltage, reference undervoltage, overtemperature and bootstrap undervoltage. From them it produces an active-low fault flag, which the pad turns into an open-drain pin, and two gate inhibit signals for the high-side and low-side drivers. Overtemperature and regulator undervoltage are held in a latch. Reference and bootstrap undervoltage are reported only while they are present. Every condition input passes through a two-flop synchronizer before it is used.

The run input is active high. While it is low, the fault flag is released and both gates are held off. The block measures each low period on this input with a free-running clock. A low period of at least `CLR_MIN` cycles clears the latch. A shorter low period is treated as a glitch and leaves the latch alone. A low period longer than `SLEEP_CYC` cycles puts the block into sleep. After sleep, a wake phase keeps both gates off and holds the flag asserted until both supply rails are out of undervoltage. Regulator undervoltage seen during this phase is part of normal start-up and is not latched.

The block has no data path, so it has no valid/ready interface. All pins are plain level signals.

Top module: `gfs_fault_supervisor`

## Requirements
- R1: `fault_n_o` is 0 exactly when `run_i` (synchronized) is high and at least one of these holds: a latched fault, a live condition, or the wake phase. It is 1 whenever run is low.
- R2: Overtemperature sets a latched fault that stays after the input clears. It never asserts either inhibit.
- R3: Regulator undervoltage asserts both inhibits only while it is present and sets a latched fault. When it clears, the inhibits drop but `fault_n_o` stays 0.
- R4: Reference undervoltage asserts `fault_n_o`=0 and both inhibits while present. It is not latched.
- R5: Bootstrap undervoltage asserts `fault_n_o`=0 and `hs_inhibit_o` only. `ls_inhibit_o` stays 0 and nothing is latched.
- R6: A run-low period of `CLR_MIN` or more cycles clears the latch. A period of `CLR_MIN`-1 or fewer cycles leaves the latch unchanged.
- R7: A run-low period of more than `SLEEP_CYC` cycles sets `sleep_o`. A period of exactly `SLEEP_CYC` cycles does not.
- R8: After sleep, while reference or regulator undervoltage is present, `fault_n_o` is 0 and both inhibits are 1. Regulator undervoltage in this phase is not latched.
- R9: A latching condition that is still present when run returns high sets the latch again on the next cycle.
- R10: A change on a condition input reaches the outputs after exactly two clock edges.
- R11: After reset, `sleep_o`=1, both inhibits are 1 and `fault_n_o`=1 while run is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that also times the run-low periods |
| rst_n | input | 1 | Asynchronous block reset, active low |
| run_i | input | 1 | Run control: low clears the latch or requests sleep |
| uv_reg_i | input | 1 | Regulator undervoltage condition |
| uv_ref_i | input | 1 | Reference undervoltage condition |
| ovt_i | input | 1 | Overtemperature condition |
| uv_boot_i | input | 1 | Bootstrap undervoltage condition |
| fault_n_o | output | 1 | Fault flag, active low, drives the open-drain pad |
| hs_inhibit_o | output | 1 | Forces the high-side gate off |
| ls_inhibit_o | output | 1 | Forces the low-side gate off |
| sleep_o | output | 1 | Sleep state |

## Verification
The bench builds the block with `CLR_MIN`=4 and `SLEEP_CYC`=20 instead of the microsecond-scale defaults. With these values the glitch boundary (3 against 4 low cycles) and the sleep boundary (20 against 21 low cycles) can each be hit exactly in a handful of cycles. The sleep boundary is observed through the latch: regulator undervoltage is held across the low period, and the flag is read after the rail recovers.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  typedef struct packed {
    logic uv_reg;
    logic uv_ref;
    logic ovt;
    logic uv_boot;
  } cond_t;

  localparam int unsigned COND_W  = $bits(cond_t);
  localparam int unsigned LATCH_W = 2;  // {uv_reg, ovt}
endpackage

// File: rtl/gfs_sync.sv
module gfs_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= {W{RST_VAL}};
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gfs_pulse_timer.sv
module gfs_pulse_timer #(
  parameter int unsigned CLR_MIN   = 200,
  parameter int unsigned SLEEP_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_s,
  output logic clr_q,
  output logic slp_q
);
  localparam int unsigned CW = $clog2(SLEEP_CYC + 1);
  localparam logic [CW-1:0] SAT   = CW'(SLEEP_CYC);
  localparam logic [CW-1:0] CLR_T = CW'(CLR_MIN - 1);

  logic [CW-1:0] lo_cnt;  // low cycles already seen in this period

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_cnt <= '0;
    else if (run_s) lo_cnt <= '0;
    else if (lo_cnt != SAT) lo_cnt <= lo_cnt + 1'b1;
  end

  assign clr_q = !run_s && (lo_cnt >= CLR_T);
  assign slp_q = !run_s && (lo_cnt == SAT);
endmodule

// File: rtl/gfs_fault_latch.sv
module gfs_fault_latch #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] lat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_o[i] <= 1'b0;
      else if (clr_i) lat_o[i] <= 1'b0;
      else if (set_en && set_i[i]) lat_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/gfs_power_seq.sv
module gfs_power_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic run_s,
  input  logic slp_q,
  input  logic rails_bad,
  output logic asleep,
  output logic waking
);
  logic wake_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) asleep <= 1'b1;
    else if (slp_q) asleep <= 1'b1;
    else if (run_s) asleep <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_hold <= 1'b0;
    else if (asleep && run_s) wake_hold <= 1'b1;
    else if (!rails_bad) wake_hold <= 1'b0;
  end

  assign waking = wake_hold || (asleep && run_s);
endmodule

// File: rtl/gfs_fault_supervisor.sv
module gfs_fault_supervisor
  import gfs_pkg::*;
#(
  parameter int unsigned CLR_MIN   = 200,
  parameter int unsigned SLEEP_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic uv_reg_i,
  input  logic uv_ref_i,
  input  logic ovt_i,
  input  logic uv_boot_i,
  output logic fault_n_o,
  output logic hs_inhibit_o,
  output logic ls_inhibit_o,
  output logic sleep_o
);
  cond_t cond_raw, cond_s;
  logic  run_s, clr_q, slp_q, asleep, waking;
  logic  uv_reg_s, uv_ref_s, ovt_s, uv_boot_s;
  logic [LATCH_W-1:0] lat;

  assign cond_raw = '{uv_reg: uv_reg_i, uv_ref: uv_ref_i, ovt: ovt_i, uv_boot: uv_boot_i};

  gfs_sync #(.W(COND_W), .STAGES(2), .RST_VAL(1'b0)) u_cond_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cond_raw), .q_o(cond_s)
  );
  gfs_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_run_sync (
    .clk(clk), .rst_n(rst_n), .d_i(run_i), .q_o(run_s)
  );

  assign uv_reg_s  = cond_s.uv_reg;
  assign uv_ref_s  = cond_s.uv_ref;
  assign ovt_s     = cond_s.ovt;
  assign uv_boot_s = cond_s.uv_boot;

  gfs_pulse_timer #(.CLR_MIN(CLR_MIN), .SLEEP_CYC(SLEEP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_s(run_s), .clr_q(clr_q), .slp_q(slp_q)
  );

  gfs_power_seq u_pwr (
    .clk(clk), .rst_n(rst_n), .run_s(run_s), .slp_q(slp_q),
    .rails_bad(uv_reg_s || uv_ref_s), .asleep(asleep), .waking(waking)
  );

  gfs_fault_latch #(.W(LATCH_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .set_en(run_s && !waking),
    .set_i({uv_reg_s, ovt_s}),
    .clr_i(clr_q),
    .lat_o(lat)
  );

  assign fault_n_o    = !(run_s && ((|lat) || (|cond_s) || waking));
  assign ls_inhibit_o = !run_s || uv_reg_s || uv_ref_s || waking;
  assign hs_inhibit_o = ls_inhibit_o || uv_boot_s;
  assign sleep_o      = asleep;
endmodule

// File: rtl/gfs_fault_sup_chk.sv
module gfs_fault_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic run_s,
  input logic uv_reg_s,
  input logic uv_ref_s,
  input logic uv_boot_s,
  input logic fault_n_o,
  input logic hs_inhibit_o,
  input logic ls_inhibit_o,
  input logic sleep_o
);
  AST_LOW_RELEASES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s |-> fault_n_o); // R1
  AST_REG_UV_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_reg_s |-> (ls_inhibit_o && hs_inhibit_o)); // R3
  AST_REF_UV_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_ref_s && run_s) |-> (ls_inhibit_o && hs_inhibit_o && !fault_n_o)); // R4
  AST_BOOT_UV_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_boot_s && run_s) |-> (hs_inhibit_o && !fault_n_o)); // R5
  AST_LS_OFF_IMPLIES_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ls_inhibit_o |-> hs_inhibit_o); // R5
  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && run_s) |=> !sleep_o); // R7
  AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> (hs_inhibit_o && ls_inhibit_o)); // R8
endmodule

bind gfs_fault_supervisor gfs_fault_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_s(run_s),
  .uv_reg_s(uv_reg_s), .uv_ref_s(uv_ref_s), .uv_boot_s(uv_boot_s),
  .fault_n_o(fault_n_o), .hs_inhibit_o(hs_inhibit_o),
  .ls_inhibit_o(ls_inhibit_o), .sleep_o(sleep_o)
);

// File: tb/gfs_fault_supervisor_tb.sv
`timescale 1ns/1ps
module gfs_fault_supervisor_tb;
  localparam int unsigned CLR_MIN   = 4;
  localparam int unsigned SLEEP_CYC = 20;

  logic clk = 1'b0, rst_n = 1'b0, run_i = 1'b0;
  logic uv_reg_i = 1'b0, uv_ref_i = 1'b0, ovt_i = 1'b0, uv_boot_i = 1'b0;
  logic fault_n_o, hs_inhibit_o, ls_inhibit_o, sleep_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gfs_fault_supervisor #(.CLR_MIN(CLR_MIN), .SLEEP_CYC(SLEEP_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .uv_reg_i(uv_reg_i), .uv_ref_i(uv_ref_i),
    .ovt_i(ovt_i), .uv_boot_i(uv_boot_i), .fault_n_o(fault_n_o),
    .hs_inhibit_o(hs_inhibit_o), .ls_inhibit_o(ls_inhibit_o), .sleep_o(sleep_o)
  );

  // condition vector order {uv_reg, uv_ref, ovt, uv_boot}
  function automatic logic e_flag_n(logic lat, logic [3:0] c);
    return !(lat || (|c));
  endfunction
  function automatic logic e_ls(logic [3:0] c);
    return c[3] || c[2];
  endfunction
  function automatic logic e_hs(logic [3:0] c);
    return c[3] || c[2] || c[0];
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_c(logic [3:0] c);
    {uv_reg_i, uv_ref_i, ovt_i, uv_boot_i} = c;
  endtask

  // low pulse on run of len cycles; optional check of the released flag mid-pulse
  task automatic pulse_run(int len, bit mid, string tag);
    run_i = 1'b0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (mid && k == 2) chk(tag, fault_n_o, 1'b1);
    end
    run_i = 1'b1;
    wait_n(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic lat_m;
    logic [3:0] c;
    void'($urandom(32'h1d5e_ed01));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    // R11 reset state
    chk("R11 sleep", sleep_o, 1'b1);
    chk("R11 hs", hs_inhibit_o, 1'b1);
    chk("R11 ls", ls_inhibit_o, 1'b1);
    chk("R11 flag", fault_n_o, 1'b1);

    // R8 wake with both rails bad
    set_c(4'b1100); run_i = 1'b1; wait_n(4);
    chk("R8 flag", fault_n_o, 1'b0);
    chk("R8 ls", ls_inhibit_o, 1'b1);
    chk("R8 sleep exit", sleep_o, 1'b0);
    set_c(4'b0100); wait_n(4);
    chk("R8 ref only", hs_inhibit_o, 1'b1);
    set_c(4'b0000); wait_n(4);
    chk("R8 no latch of reg uv", fault_n_o, 1'b1);
    chk("R8 hs released", hs_inhibit_o, 1'b0);

    // R10 latency
    uv_ref_i = 1'b1;
    wait_n(1); chk("R10 one edge", fault_n_o, 1'b1);
    wait_n(1); chk("R10 two edges", fault_n_o, 1'b0);
    uv_ref_i = 1'b0; wait_n(4);
    chk("R4 not latched", fault_n_o, 1'b1);

    // R2 overtemperature
    ovt_i = 1'b1; wait_n(4);
    chk("R2 flag", fault_n_o, 1'b0);
    chk("R2 no hs", hs_inhibit_o, 1'b0);
    chk("R2 no ls", ls_inhibit_o, 1'b0);
    ovt_i = 1'b0; wait_n(4);
    chk("R2 latched", fault_n_o, 1'b0);

    // R6 glitch versus qualified clear
    pulse_run(CLR_MIN - 1, 1'b1, "R1 masked in pulse");
    chk("R6 short pulse keeps latch", fault_n_o, 1'b0);
    pulse_run(CLR_MIN, 1'b1, "R1 masked in pulse");
    chk("R6 clear", fault_n_o, 1'b1);

    // R3 regulator undervoltage
    uv_reg_i = 1'b1; wait_n(4);
    chk("R3 ls", ls_inhibit_o, 1'b1);
    chk("R3 hs", hs_inhibit_o, 1'b1);
    uv_reg_i = 1'b0; wait_n(4);
    chk("R3 gates back", ls_inhibit_o, 1'b0);
    chk("R3 hs back", hs_inhibit_o, 1'b0);
    chk("R3 flag latched", fault_n_o, 1'b0);
    pulse_run(CLR_MIN, 1'b0, "");

    // R5 bootstrap
    uv_boot_i = 1'b1; wait_n(4);
    chk("R5 flag", fault_n_o, 1'b0);
    chk("R5 hs", hs_inhibit_o, 1'b1);
    chk("R5 ls", ls_inhibit_o, 1'b0);
    uv_boot_i = 1'b0; wait_n(4);
    chk("R5 not latched", fault_n_o, 1'b1);

    // R9 relatch from condition held across clear pulse
    ovt_i = 1'b1; wait_n(4);
    pulse_run(CLR_MIN, 1'b1, "R1 masked in pulse");
    ovt_i = 1'b0; wait_n(4);
    chk("R9 relatched", fault_n_o, 1'b0);
    pulse_run(CLR_MIN, 1'b0, "");
    chk("R9 cleared", fault_n_o, 1'b1);

    // R7 boundary: exactly SLEEP_CYC low, regulator uv held -> relatches (no sleep)
    uv_reg_i = 1'b1; wait_n(4);
    pulse_run(SLEEP_CYC, 1'b0, "");
    uv_reg_i = 1'b0; wait_n(4);
    chk("R7 no sleep at limit", fault_n_o, 1'b0);
    pulse_run(CLR_MIN, 1'b0, "");
    // one more cycle -> sleep, wake suppresses latch
    uv_reg_i = 1'b1; wait_n(4);
    pulse_run(SLEEP_CYC + 1, 1'b0, "");
    uv_reg_i = 1'b0; wait_n(4);
    chk("R7 sleep past limit", fault_n_o, 1'b1);

    // R7 long low
    ovt_i = 1'b1; run_i = 1'b0; wait_n(SLEEP_CYC + 6);
    chk("R7 sleep_o", sleep_o, 1'b1);
    chk("R1 flag released in sleep", fault_n_o, 1'b1);
    chk("R11 gates off in sleep", hs_inhibit_o, 1'b1);
    ovt_i = 1'b0; run_i = 1'b1; wait_n(4);
    chk("R7 awake", sleep_o, 1'b0);
    chk("R6 sleep cleared latch", fault_n_o, 1'b1);

    // random phase against bench model, run high
    lat_m = 1'b0;
    for (int it = 0; it < 60; it++) begin
      c = 4'($urandom_range(0, 15));
      set_c(c); wait_n(4);
      lat_m = lat_m || c[3] || c[1];
      chk("R1 random flag", fault_n_o, e_flag_n(lat_m, c));
      chk("R4 random ls", ls_inhibit_o, e_ls(c));
      chk("R5 random hs", hs_inhibit_o, e_hs(c));
      if (it % 7 == 6) begin
        pulse_run(CLR_MIN, 1'b0, "");
        lat_m = c[3] || c[1];
        chk("R9 random relatch", fault_n_o, e_flag_n(lat_m, c));
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule